// File: doc/BRIEF.md
# Operand Dependency Hazard Checker

This block decides whether the source operand of the instruction being issued now relies on the result of the instruction issued one slot earlier. Each operand is presented as a small descriptor: a presence flag, a two-bit addressing mode and a register number. The block keeps the destination descriptor of the previous instruction in a register. It compares that stored descriptor with the current source descriptor through a fixed set of rules that depend on the mode pair.

Register equality alone does not decide the outcome. An immediate source or an absolute address never creates a hazard. A pair of register-direct operands is a hazard only when their registers match. An indirect source is tested against the base register it uses. When both operands use memory through register-indirect addressing, the pair is always a hazard, so the earlier store is ordered ahead of the later load. The verdict is a single combinational bit that a scheduler can sample in the same cycle in which the source is presented.

Top module: `opnd_dep_detect`

## Requirements
- R1: Mode encoding is 2'b00 immediate, 2'b01 register direct, 2'b10 address, 2'b11 register indirect; a valid source in immediate mode gives dep_o = 0 whatever the stored destination.
- R2: A register-direct source against a register-direct destination gives dep_o = 1 exactly when the two register fields are equal.
- R3: A register-direct source against a register-indirect destination gives dep_o = 0, even with equal registers.
- R4: A register-indirect source against a register-direct destination gives dep_o = 1 exactly when the source base register equals the destination register.
- R5: A register-indirect source against a register-indirect destination gives dep_o = 1 for any pair of register fields.
- R6: An address-mode operand on either side gives dep_o = 0.
- R7: A source with its valid flag low, or a stored destination with its valid flag low, gives dep_o = 0.
- R8: The destination descriptor is captured at a rising clock edge where issue_i is high and is held unchanged while issue_i is low; dep_o follows the source inputs in the same cycle, with no register.
- R9: Reset (rst_n low, asynchronous) clears the stored destination, so dep_o = 0 for any source until the next issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Issue pulse; captures the destination descriptor |
| dst_vld_i | input | 1 | Destination operand present |
| dst_mode_i | input | 2 | Destination addressing mode |
| dst_reg_i | input | REG_W | Destination register or base register |
| src_vld_i | input | 1 | Source operand present |
| src_mode_i | input | 2 | Source addressing mode |
| src_reg_i | input | REG_W | Source register or base register |
| dep_o | output | 1 | Source depends on the stored destination |

## Verification
A destination descriptor takes effect one rising edge after it is issued, and a source descriptor affects dep_o in the same cycle with no edge in between. For each case the bench drives the destination with issue_i high at a falling edge. It lets one rising edge capture it, then drops issue_i and applies the source at the next falling edge. It samples dep_o a couple of nanoseconds later, well before the following rising edge. The hold and reset cases change inputs between edges and sample in the same way, so every check reads a settled combinational result from a known register state.

// File: rtl/opnd_dep_pkg.sv
package opnd_dep_pkg;

   typedef enum logic [1:0] {
      OPM_IMM  = 2'b00,
      OPM_REG  = 2'b01,
      OPM_ADDR = 2'b10,
      OPM_IND  = 2'b11
   } opmode_e;

   localparam int MODE_W = 2;

endpackage

// File: rtl/opnd_dst_hold.sv
module opnd_dst_hold
   import opnd_dep_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             vld_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [REG_W-1:0] reg_i,
   output logic             vld_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [REG_W-1:0] reg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         mode_q <= OPM_IMM;
         reg_q  <= '0;
      end else if (load_i) begin
         vld_q  <= vld_i;
         mode_q <= mode_i;
         reg_q  <= reg_i;
      end
   end

endmodule

// File: rtl/opnd_dep_rules.sv
module opnd_dep_rules
   import opnd_dep_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic              d_vld_i,
   input  logic [MODE_W-1:0] d_mode_i,
   input  logic [REG_W-1:0]  d_reg_i,
   input  logic              s_vld_i,
   input  logic [MODE_W-1:0] s_mode_i,
   input  logic [REG_W-1:0]  s_reg_i,
   output logic              hit_o
);

   opmode_e d_mode, s_mode;
   logic    same_reg;

   assign d_mode   = opmode_e'(d_mode_i);
   assign s_mode   = opmode_e'(s_mode_i);
   assign same_reg = (d_reg_i == s_reg_i);

   always_comb begin
      hit_o = 1'b0;
      if (d_vld_i && s_vld_i) begin
         unique case (s_mode)
            OPM_REG:  hit_o = (d_mode == OPM_REG) && same_reg;
            OPM_IND: begin
               if (d_mode == OPM_IND)      hit_o = 1'b1;
               else if (d_mode == OPM_REG) hit_o = same_reg;
               else                        hit_o = 1'b0;
            end
            default:  hit_o = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/opnd_dep_detect.sv
module opnd_dep_detect
   import opnd_dep_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  logic             dst_vld_i,
   input  logic [1:0]       dst_mode_i,
   input  logic [REG_W-1:0] dst_reg_i,
   input  logic             src_vld_i,
   input  logic [1:0]       src_mode_i,
   input  logic [REG_W-1:0] src_reg_i,
   output logic             dep_o
);

   generate
      if (REG_W < 1 || REG_W > 16) begin : g_bad_width
         $error("opnd_dep_detect: REG_W must lie in 1..16");
      end
   endgenerate

   logic              prev_vld;
   logic [MODE_W-1:0] prev_mode;
   logic [REG_W-1:0]  prev_reg;

   opnd_dst_hold #(.REG_W(REG_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (issue_i),
      .vld_i  (dst_vld_i),
      .mode_i (dst_mode_i),
      .reg_i  (dst_reg_i),
      .vld_q  (prev_vld),
      .mode_q (prev_mode),
      .reg_q  (prev_reg)
   );

   opnd_dep_rules #(.REG_W(REG_W)) u_rules (
      .d_vld_i  (prev_vld),
      .d_mode_i (prev_mode),
      .d_reg_i  (prev_reg),
      .s_vld_i  (src_vld_i),
      .s_mode_i (src_mode_i),
      .s_reg_i  (src_reg_i),
      .hit_o    (dep_o)
   );

endmodule

// File: rtl/opnd_dep_detect_chk.sv
module opnd_dep_detect_chk #(
   parameter int REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue_i,
   input logic             dst_vld_i,
   input logic [1:0]       dst_mode_i,
   input logic [REG_W-1:0] dst_reg_i,
   input logic             src_vld_i,
   input logic [1:0]       src_mode_i,
   input logic [REG_W-1:0] src_reg_i,
   input logic             dep_o
);

   AST_IMM_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (src_vld_i && src_mode_i == 2'b00) |-> !dep_o); // R1

   AST_ADDR_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode_i == 2'b10) |-> !dep_o); // R6

   AST_ABSENT_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !src_vld_i |-> !dep_o); // R7

   AST_ABSENT_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !dst_vld_i) |=> !dep_o); // R7

   AST_IND_PAIR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && dst_vld_i && dst_mode_i == 2'b11) |=>
      ((src_vld_i && src_mode_i == 2'b11) -> dep_o)); // R5

   AST_REG_AFTER_IND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && dst_mode_i == 2'b11) |=>
      ((src_mode_i == 2'b01) -> !dep_o)); // R3

   AST_REG_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && dst_vld_i && dst_mode_i == 2'b01) |=>
      ((src_vld_i && src_mode_i == 2'b01) ->
       (dep_o == (src_reg_i == $past(dst_reg_i))))); // R2

endmodule

bind opnd_dep_detect opnd_dep_detect_chk #(.REG_W(REG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .issue_i    (issue_i),
   .dst_vld_i  (dst_vld_i),
   .dst_mode_i (dst_mode_i),
   .dst_reg_i  (dst_reg_i),
   .src_vld_i  (src_vld_i),
   .src_mode_i (src_mode_i),
   .src_reg_i  (src_reg_i),
   .dep_o      (dep_o)
);

// File: tb/opnd_dep_detect_test.sv
module opnd_dep_detect_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue_i = 1'b0;
   logic       dst_vld_i = 1'b0;
   logic [1:0] dst_mode_i = 2'b00;
   logic [4:0] dst_reg_i = '0;
   logic       src_vld_i = 1'b0;
   logic [1:0] src_mode_i = 2'b00;
   logic [4:0] src_reg_i = '0;
   logic       dep_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   opnd_dep_detect #(.REG_W(5)) uut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i),
      .dst_vld_i(dst_vld_i), .dst_mode_i(dst_mode_i), .dst_reg_i(dst_reg_i),
      .src_vld_i(src_vld_i), .src_mode_i(src_mode_i), .src_reg_i(src_reg_i),
      .dep_o(dep_o)
   );

   // row: {dst_vld, dst_mode, dst_reg, src_vld, src_mode, src_reg, expected}
   localparam int NV = 15;
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 2'd1, 5'd3,  1'b1, 2'd0, 5'd3,  1'b0},  // R1 imm source
      {1'b1, 2'd1, 5'd3,  1'b1, 2'd1, 5'd3,  1'b1},  // R2 equal regs
      {1'b1, 2'd1, 5'd3,  1'b1, 2'd1, 5'd4,  1'b0},  // R2 differing regs
      {1'b1, 2'd3, 5'd3,  1'b1, 2'd1, 5'd3,  1'b0},  // R3 direct after indirect
      {1'b1, 2'd1, 5'd7,  1'b1, 2'd3, 5'd7,  1'b1},  // R4 base match
      {1'b1, 2'd1, 5'd7,  1'b1, 2'd3, 5'd8,  1'b0},  // R4 base differs
      {1'b1, 2'd3, 5'd1,  1'b1, 2'd3, 5'd30, 1'b1},  // R5 any regs
      {1'b1, 2'd3, 5'd5,  1'b1, 2'd3, 5'd5,  1'b1},  // R5 same regs
      {1'b1, 2'd2, 5'd2,  1'b1, 2'd1, 5'd2,  1'b0},  // R6 address dst
      {1'b1, 2'd1, 5'd2,  1'b1, 2'd2, 5'd2,  1'b0},  // R6 address src
      {1'b1, 2'd2, 5'd2,  1'b1, 2'd3, 5'd2,  1'b0},  // R6 address dst, indirect src
      {1'b0, 2'd1, 5'd9,  1'b1, 2'd1, 5'd9,  1'b0},  // R7 dst absent
      {1'b1, 2'd1, 5'd9,  1'b0, 2'd1, 5'd9,  1'b0},  // R7 src absent
      {1'b1, 2'd3, 5'd6,  1'b1, 2'd0, 5'd6,  1'b0},  // R1 imm after indirect
      {1'b1, 2'd1, 5'd31, 1'b1, 2'd1, 5'd31, 1'b1}   // R2 top register
   };

   task automatic check(input string tag, input logic exp);
      n_run++;
      if (dep_o !== exp) begin
         n_fail++;
         $display("FAIL %s: dep_o actual=%b expected=%b", tag, dep_o, exp);
      end
   endtask

   task automatic set_src(input logic v, input logic [1:0] m, input logic [4:0] r);
      src_vld_i = v; src_mode_i = m; src_reg_i = r;
   endtask

   task automatic issue_dst(input logic v, input logic [1:0] m, input logic [4:0] r);
      @(negedge clk);
      dst_vld_i = v; dst_mode_i = m; dst_reg_i = r; issue_i = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      set_src(1'b1, 2'd1, 5'd0);
      #2 check("R9 reset state", 1'b0);
      rst_n = 1'b1;
      @(negedge clk); #2 check("R9 after release", 1'b0);

      for (int i = 0; i < NV; i++) begin
         issue_dst(VEC[i][16], VEC[i][15:14], VEC[i][13:9]);
         set_src(VEC[i][8], VEC[i][7:6], VEC[i][5:1]);
         #2;
         n_run++;
         if (dep_o !== VEC[i][0]) begin
            n_fail++;
            $display("FAIL table row %0d (R1..R7 rule rows): dep_o actual=%b expected=%b",
                     i, dep_o, VEC[i][0]);
         end
      end

      // R8: hold while issue_i low, and same-cycle source response
      issue_dst(1'b1, 2'd1, 5'd4);
      dst_vld_i = 1'b1; dst_mode_i = 2'd1; dst_reg_i = 5'd9;
      set_src(1'b1, 2'd1, 5'd4);
      @(negedge clk); #2 check("R8 held destination", 1'b1);
      set_src(1'b1, 2'd1, 5'd9);
      #2 check("R8 unissued destination ignored", 1'b0);
      set_src(1'b1, 2'd1, 5'd4);
      #2 check("R8 same-cycle source", 1'b1);

      // R9: reset clears stored destination
      issue_dst(1'b1, 2'd3, 5'd12);
      set_src(1'b1, 2'd3, 5'd12);
      #2 check("R9 before reset", 1'b1);
      rst_n = 1'b0;
      #2 check("R9 during reset", 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #2 check("R9 cleared after reset", 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule